// File: doc/BRIEF.md
# Multi-Mode Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It counts strobes from one of two input sources and emits a one-clock pulse each time a programmed number of strobes has been counted. The pulse goes to a phase comparator, which is outside this block. Both inputs are modelled as clock-enable strobes in the block's own clock domain.

Two select bits choose the mode:

- **Wide mode with halving.** A fixed divide-by-two stage runs ahead of the counter on the fast input. The ratio is the full 16-bit word.
- **Wide direct mode.** The slower input is counted directly, and the ratio is the full word.
- **Narrow mode.** The slower input is counted directly. The ratio is the upper twelve bits of the word, and the lowest four bits do not matter.

A ratio below the mode's floor is raised to that floor. A new ratio takes effect only at the end of the cycle in progress. An inhibit input holds the divider stopped.

Example ratios:

- A 100.7 MHz source with a 25 kHz reference in the halving mode uses ratio 2014 (0x07DE).
- A 22.2 MHz source with a 5 kHz reference in wide direct mode uses 4440 (0x1158).
- A 1458 kHz source with a 9 kHz reference in narrow mode places 162 (0x0A2) in bits 15..4.

Top module: `fbdiv_multimode`

## Requirements
- R1: With `path_sel`=1 (`range_sel` ignored), only `hi_strobe` is counted, `ratio_word[15:0]` is the ratio N, and one pulse is emitted every 2N `hi_strobe` events.
- R2: With `path_sel`=0 and `range_sel`=1, only `lo_strobe` is counted, `ratio_word[15:0]` is N, and one pulse is emitted every N events.
- R3: With `path_sel`=0 and `range_sel`=0, only `lo_strobe` is counted, N is `ratio_word[15:4]` (4..4095), and `ratio_word[3:0]` has no effect on the period.
- R4: The input that the mode does not select has no effect: strobes on it alone produce no pulse.
- R5: In the two wide modes, a ratio below 272 acts as 272 (544 strobes in the halving mode). In narrow mode, a field below 4 acts as 4.
- R6: While `inhibit` is 1, no pulse is emitted, and the count and the halving stage are cleared. After release, the first pulse comes after a full period.
- R7: A ratio written in the middle of a cycle does not change that cycle. It governs the cycles after the next terminal count.
- R8: `div_pulse` is high for exactly one clock. It rises in the cycle after the clock edge that takes the completing strobe.
- R9: While `rst_n` is 0 at a clock edge (synchronous, active low), `div_pulse` is 0 and the next cycle starts from an empty count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_strobe | input | 1 | Strobe from the fast source (halving path) |
| lo_strobe | input | 1 | Strobe from the slower source |
| path_sel | input | 1 | 1 selects the fast source through the halving stage |
| range_sel | input | 1 | With `path_sel`=0: 1 selects the 16-bit ratio, 0 selects the 12-bit ratio |
| inhibit | input | 1 | Stops division and clears the cycle |
| ratio_word | input | 16 | Programmed ratio word |
| div_pulse | output | 1 | One-clock pulse per division cycle |

## Verification
The main function is exercised with the worked ratios of all three modes, each with dense and with sparse strobe patterns. The first and second periods of every run are both measured, which separates a stale ratio from an off-by-one restart. The unselected input is held busy throughout, so a wrong source choice shows up as a wrong period. In narrow mode, the same field is tried with different low nibbles, and ratios just under each floor are tried so that clamping can be told apart from wraparound. A change of ratio in the middle of a cycle, and an inhibit taken on an odd strobe of the halving path, show whether reloads and the halving stage obey cycle boundaries.

// File: rtl/fbdiv_multimode.sv
`timescale 1ns/1ps
module fbdiv_multimode #(
  parameter int WORD_W     = 16,
  parameter int FIELD_LSB  = 4,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_strobe,
  input  logic              lo_strobe,
  input  logic              path_sel,
  input  logic              range_sel,
  input  logic              inhibit,
  input  logic [WORD_W-1:0] ratio_word,
  output logic              div_pulse
);
  localparam int NARROW_W = WORD_W - FIELD_LSB;
  localparam logic [WORD_W-1:0] WIDE_FLOOR   = WORD_W'(WIDE_MIN);
  localparam logic [WORD_W-1:0] NARROW_FLOOR = WORD_W'(NARROW_MIN);

  logic [WORD_W-1:0] narrow_n, next_n, period, cnt;
  logic              halve_q, count_evt, wide_mode;

  assign wide_mode = path_sel | range_sel;
  assign narrow_n  = {{FIELD_LSB{1'b0}}, ratio_word[WORD_W-1 -: NARROW_W]};
  assign next_n    = wide_mode
                   ? ((ratio_word < WIDE_FLOOR)  ? WIDE_FLOOR   : ratio_word)
                   : ((narrow_n   < NARROW_FLOOR) ? NARROW_FLOOR : narrow_n);
  assign count_evt = path_sel ? (hi_strobe & halve_q) : lo_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n || inhibit) begin
      cnt       <= '0;
      period    <= next_n;
      halve_q   <= 1'b0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= 1'b0;
      if (path_sel && hi_strobe) halve_q <= ~halve_q;
      if (count_evt) begin
        if (cnt == period - 1'b1) begin
          cnt       <= '0;
          period    <= next_n;
          div_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fbdiv_multimode_chk.sv
`timescale 1ns/1ps
module fbdiv_multimode_chk #(
  parameter int WORD_W     = 16,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hi_strobe,
  input logic              lo_strobe,
  input logic              path_sel,
  input logic              range_sel,
  input logic              inhibit,
  input logic              div_pulse,
  input logic [WORD_W-1:0] period
);
  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_pulse_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> ($past(path_sel ? hi_strobe : lo_strobe) && !$past(inhibit)));

  assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !div_pulse);

  assert_narrow_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (period >= WORD_W'(NARROW_MIN)));

  assert_wide_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && (path_sel || range_sel)) |=> (period >= WORD_W'(WIDE_MIN)));
endmodule

bind fbdiv_multimode fbdiv_multimode_chk #(
  .WORD_W(WORD_W), .WIDE_MIN(WIDE_MIN), .NARROW_MIN(NARROW_MIN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hi_strobe(hi_strobe), .lo_strobe(lo_strobe),
  .path_sel(path_sel), .range_sel(range_sel), .inhibit(inhibit),
  .div_pulse(div_pulse), .period(period)
);

// File: tb/fbdiv_multimode_tb_top.sv
`timescale 1ns/1ps
module fbdiv_multimode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_strobe = 1'b0, lo_strobe = 1'b0;
  logic        path_sel = 1'b0, range_sel = 1'b0, inhibit = 1'b1;
  logic [15:0] ratio_word = 16'h0040;
  logic        div_pulse;
  int          n_checks = 0, n_fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  fbdiv_multimode dut_i (
    .clk(clk), .rst_n(rst_n), .hi_strobe(hi_strobe), .lo_strobe(lo_strobe),
    .path_sel(path_sel), .range_sel(range_sel), .inhibit(inhibit),
    .ratio_word(ratio_word), .div_pulse(div_pulse)
  );

  // {path_sel, range_sel, ratio_word, strobe gap, expected strobes per pulse}
  localparam int NV = 12;
  localparam logic [41:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 16'h07DE, 4'd1, 20'd4028},  // R1
    {1'b1, 1'b1, 16'h0110, 4'd2, 20'd544},   // R1, range_sel ignored
    {1'b0, 1'b1, 16'h1158, 4'd1, 20'd4440},  // R2
    {1'b0, 1'b1, 16'h0111, 4'd3, 20'd273},   // R2
    {1'b0, 1'b0, 16'h0A2F, 4'd1, 20'd162},   // R3
    {1'b0, 1'b0, 16'h0A20, 4'd2, 20'd162},   // R3 low nibble ignored
    {1'b0, 1'b0, 16'h0040, 4'd1, 20'd4},     // R3 lower bound
    {1'b0, 1'b0, 16'hFFF5, 4'd1, 20'd4095},  // R3 upper bound
    {1'b0, 1'b1, 16'h0064, 4'd1, 20'd272},   // R5
    {1'b1, 1'b0, 16'h0005, 4'd1, 20'd544},   // R5
    {1'b0, 1'b0, 16'h001F, 4'd1, 20'd4},     // R5
    {1'b0, 1'b0, 16'h0000, 4'd2, 20'd4}      // R5
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic configure(input bit ps, input bit rs, input logic [15:0] w);
    @(negedge clk);
    inhibit = 1'b1; hi_strobe = 1'b0; lo_strobe = 1'b0;
    path_sel = ps; range_sel = rs; ratio_word = w;
    @(negedge clk);
    inhibit = 1'b0;
  endtask

  // Counts selected strobes between pulses; the unselected input stays busy (R4).
  task automatic run_periods(input bit use_hi, input int gap, input int exp_first,
                             input int exp_rest, input string tag, input int nper);
    int consumed = 0, seen = 0, cyc = 0;
    bit prev = 1'b0, s;
    while (seen < nper && cyc < (exp_first + exp_rest) * gap * 2 + 50) begin
      @(negedge clk);
      if (div_pulse) begin
        check(!prev, "R8 width", 1, 0);
        check(consumed == ((seen == 0) ? exp_first : exp_rest), tag, consumed,
              (seen == 0) ? exp_first : exp_rest);
        seen++;
        consumed = 0;
      end
      prev = div_pulse;
      s = ((cyc % gap) == 0);
      hi_strobe = use_hi ? s : 1'b1;
      lo_strobe = use_hi ? 1'b1 : s;
      consumed += int'(s);
      cyc++;
    end
    hi_strobe = 1'b0; lo_strobe = 1'b0;
    check(seen == nper, {tag, " pulse count"}, seen, nper);
  endtask

  task automatic count_quiet(input int cycles, input string tag);
    int pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      pulses += int'(div_pulse);
    end
    check(pulses == 0, tag, pulses, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R9: reset holds the pulse low even with strobes present
    hi_strobe = 1'b1; lo_strobe = 1'b1; inhibit = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(div_pulse == 1'b0, "R9 reset", int'(div_pulse), 0);
    end
    hi_strobe = 1'b0; lo_strobe = 1'b0;
    rst_n = 1'b1;
    run_periods(1'b0, 1, 4, 4, "R9 fresh cycle after reset", 2);

    for (int v = 0; v < NV; v++) begin
      string tag;
      logic [41:0] e = VEC[v];
      tag = (v >= 8) ? "R5 clamp" : (e[41] ? "R1 halving" : (e[40] ? "R2 direct" : "R3 narrow"));
      configure(e[41], e[40], e[39:24]);
      run_periods(e[41], int'(e[23:20]), int'(e[19:0]), int'(e[19:0]), tag, 2);
    end

    // R4: only the unselected input strobes
    configure(1'b0, 1'b1, 16'h0110);
    hi_strobe = 1'b1;
    count_quiet(700, "R4 hi ignored in direct mode");
    configure(1'b1, 1'b0, 16'h0110);
    lo_strobe = 1'b1;
    count_quiet(700, "R4 lo ignored in halving mode");

    // R7: ratio changed mid-cycle
    configure(1'b0, 1'b1, 16'd300);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); lo_strobe = 1'b1;
    end
    ratio_word = 16'd400;
    run_periods(1'b0, 1, 200, 400, "R7 reload at terminal count", 2);

    // R6: inhibit mid-cycle in narrow mode
    configure(1'b0, 1'b0, 16'h00A0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); lo_strobe = 1'b1;
    end
    @(negedge clk); inhibit = 1'b1;
    count_quiet(40, "R6 quiet while inhibited");
    inhibit = 1'b0; lo_strobe = 1'b0;
    run_periods(1'b0, 1, 10, 10, "R6 full period after release", 2);

    // R6: inhibit on an odd strobe of the halving path clears the halving stage
    configure(1'b1, 1'b0, 16'h0110);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); hi_strobe = 1'b1;
    end
    @(negedge clk); hi_strobe = 1'b0; inhibit = 1'b1;
    @(negedge clk); inhibit = 1'b0;
    run_periods(1'b1, 1, 544, 544, "R6 halving stage cleared", 1);

    // R8: dense narrow pulses at the lower bound
    configure(1'b0, 1'b0, 16'h0040);
    run_periods(1'b0, 1, 4, 4, "R8 pulse timing", 4);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule